// File: doc/BRIEF.md
# SPI Flash Boot Stream Reader

After reset this block pulls a boot image out of a serial flash memory and hands it to the rest of the chip as a byte stream. It waits until two active-low hold-off inputs are both released. It then opens one read transaction at flash address zero and keeps clocking data in until the programmed number of bytes has been delivered. There is no second attempt. Other chip selects on the shared serial bus are held inactive for the whole transfer.

The serial clock starts at its slowest rate. A rate request raises it to a divisor-selected faster rate. The new rate never goes past a configured ceiling and takes effect only between bytes. An optional fast-read command inserts a dummy byte after the address for use at the higher rates. Received bytes leave on a valid/ready port. While the consumer stalls, the serial clock stops at a byte boundary. When the last byte is taken, a one-cycle done pulse fires with a blank-image error flag. The bus is then either parked with chip select high or handed to user logic.

Top module: `boot_stream_reader`

## Requirements
- R1: While either `holdAN` or `holdBN` is low, `csN` stays high and `sclk` does not toggle. Once both are high, `csN` falls on the third rising clock edge (two synchronizer stages plus the state register).
- R2: `csN` falls exactly once per reset. The read command is sent once and never reissued.
- R3: Serial transfers use SPI mode 0 (`sclk` idles low, `miso` sampled on the rising edge) and send MSB first. With `fastMode` low at start the header is 0x03 followed by three 0x00 address bytes. With `fastMode` high it is 0x0B, three 0x00 address bytes and one 0x00 dummy byte. `fastMode` is sampled when the transaction starts.
- R4: The data bytes after the header appear on `dataOut` in flash order, each with `dataValid`. `dataOut` holds steady while `dataValid` is high and `dataReady` is low.
- R5: Until a rate request, every `sclk` high and low phase lasts `SLOW_HALF` clock cycles.
- R6: After `rateUp` is seen (once the transaction has started), each byte that begins later uses a half period of max(`fastDiv`, `MIN_HALF`) clock cycles. A half period never changes inside a byte.
- R7: While `dataValid` is high and `dataReady` is low, no further serial clock edges are produced.
- R8: `done` is high for exactly one cycle, in the cycle after the handshake of byte `byteCount`-1 (counting from 0). From then on `bootErr` is 1 if every data byte was 0xFF and 0 otherwise. `byteCount` must be at least 1.
- R9: With `keepBus` low at start, after `done` `csN` stays high, `sclk` stays low and `busGrant` stays low.
- R10: With `keepBus` high at start, `busGrant` rises with `done` and stays high. `sclk`, `mosi`, `csN` and `periphCsN` then follow `userSclk`, `userMosi`, `userCsN` and `userPeriphCsN`.
- R11: While `busGrant` is low, every bit of `periphCsN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| holdAN | input | 1 | Hold-off input A, active low |
| holdBN | input | 1 | Hold-off input B, active low |
| byteCount | input | CNT_W | Number of image bytes to deliver |
| fastMode | input | 1 | Use the fast-read command with a dummy byte |
| rateUp | input | 1 | Request to raise the serial clock rate |
| fastDiv | input | DIV_W | Half-period in clock cycles for the fast rate |
| keepBus | input | 1 | 1: hand the bus to user logic afterwards; 0: park it |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| periphCsN | output | NUM_PERIPH | Selects of other bus peripherals |
| dataOut | output | 8 | Image byte |
| dataValid | output | 1 | `dataOut` holds a byte |
| dataReady | input | 1 | Consumer accepts the byte |
| done | output | 1 | One-cycle completion pulse |
| bootErr | output | 1 | Every image byte read as 0xFF |
| busGrant | output | 1 | Bus pins follow the user inputs |
| userSclk | input | 1 | User serial clock after the grant |
| userMosi | input | 1 | User serial data after the grant |
| userCsN | input | 1 | User flash select after the grant |
| userPeriphCsN | input | NUM_PERIPH | User peripheral selects after the grant |

## Verification
Two functions can meet in the same cycle. A rate request can arrive while a byte is already on the wire, and a consumer stall can fall exactly at a byte boundary. The bench pulses `rateUp` in the middle of a data byte and records the length of every serial clock phase. Each byte's eight phases must be equal: slow before the request and at the clamped fast rate after it. It then holds `dataReady` low over a boundary and confirms that no rising edges occur and that the held byte does not change.

// File: rtl/boot_reader_pkg.sv
`timescale 1ns/1ps
package boot_reader_pkg;

  localparam logic [7:0] CMD_READ = 8'h03;
  localparam logic [7:0] CMD_FAST = 8'h0B;

  // Strobes from control to the serial datapath.
  typedef struct packed {
    logic       startByte;
    logic [7:0] txByte;
    logic       useFast;
  } ctrlCmd_t;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_HDR,
    ST_DATA,
    ST_PARK,
    ST_GRANT
  } bootState_t;

endpackage

// File: rtl/boot_shift_dp.sv
`timescale 1ns/1ps
module boot_shift_dp
  import boot_reader_pkg::*;
#(
  parameter int SLOW_HALF = 8,
  parameter int DIV_W     = 4,
  parameter int MIN_HALF  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlCmd_t         cmd,
  input  logic [DIV_W-1:0] fastDiv,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             byteDone,
  output logic [7:0]       rxByte
);

  localparam int SLOW_W = $clog2(SLOW_HALF + 1);
  localparam int HW     = (DIV_W > SLOW_W) ? DIV_W : SLOW_W;

  logic [HW-1:0] fastHalf;
  logic [HW-1:0] halfLat;
  logic [HW-1:0] cnt;
  logic [2:0]    bitCnt;
  logic [7:0]    txSh;
  logic [7:0]    rxSh;
  logic          busy;

  // Fast rate never exceeds the configured ceiling.
  always_comb begin
    if (HW'(fastDiv) < HW'(MIN_HALF)) fastHalf = HW'(MIN_HALF);
    else                              fastHalf = HW'(fastDiv);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfLat  <= HW'(SLOW_HALF);
      cnt      <= '0;
      bitCnt   <= '0;
      txSh     <= '0;
      rxSh     <= '0;
      busy     <= 1'b0;
      sclk     <= 1'b0;
      byteDone <= 1'b0;
      rxByte   <= '0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.startByte && !busy) begin
        busy    <= 1'b1;
        halfLat <= cmd.useFast ? fastHalf : HW'(SLOW_HALF);
        cnt     <= '0;
        bitCnt  <= '0;
        txSh    <= cmd.txByte;
        sclk    <= 1'b0;
      end else if (busy) begin
        if (cnt == halfLat - 1'b1) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitCnt == 3'd7) begin
              busy     <= 1'b0;
              byteDone <= 1'b1;
              rxByte   <= rxSh;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mosi = txSh[7];

  AST_HALF_FIXED_IN_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(halfLat)); // R6
  AST_HALF_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (halfLat >= HW'(MIN_HALF))); // R6
  AST_CLOCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk); // R3

endmodule

// File: rtl/boot_ctrl.sv
`timescale 1ns/1ps
module boot_ctrl
  import boot_reader_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdAN,
  input  logic             holdBN,
  input  logic [CNT_W-1:0] byteCount,
  input  logic             fastMode,
  input  logic             rateUp,
  input  logic             keepBus,
  input  logic             byteDone,
  input  logic [7:0]       rxByte,
  input  logic             dataReady,
  output ctrlCmd_t         cmd,
  output logic             csN,
  output logic             busGrant,
  output logic             dataValid,
  output logic [7:0]       dataOut,
  output logic             done,
  output logic             bootErr
);

  bootState_t       state;
  logic [1:0]       relA, relB;
  logic [2:0]       hdrIdx;
  logic [2:0]       hdrLast;
  logic             inFlight;
  logic             fastLat, keepLat, rateHigh, allOnes;
  logic [CNT_W-1:0] countLat, startedCnt, acceptCnt;
  logic             canStart;
  logic [7:0]       hdrByte;
  logic             released;

  assign released = relA[1] && relB[1];
  assign hdrLast  = fastLat ? 3'd4 : 3'd3;
  assign hdrByte  = (hdrIdx == 3'd0) ? (fastLat ? CMD_FAST : CMD_READ) : 8'h00;

  always_comb begin
    canStart = 1'b0;
    if (!inFlight) begin
      if (state == ST_HDR) canStart = 1'b1;
      else if (state == ST_DATA && !dataValid && startedCnt != countLat) canStart = 1'b1;
    end
    cmd.startByte = canStart;
    cmd.txByte    = (state == ST_HDR) ? hdrByte : 8'h00;
    cmd.useFast   = rateHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relA       <= '0;
      relB       <= '0;
      state      <= ST_WAIT;
      hdrIdx     <= '0;
      inFlight   <= 1'b0;
      fastLat    <= 1'b0;
      keepLat    <= 1'b0;
      rateHigh   <= 1'b0;
      allOnes    <= 1'b1;
      countLat   <= '0;
      startedCnt <= '0;
      acceptCnt  <= '0;
      dataValid  <= 1'b0;
      dataOut    <= '0;
      done       <= 1'b0;
      bootErr    <= 1'b0;
    end else begin
      relA <= {relA[0], holdAN};
      relB <= {relB[0], holdBN};
      done <= 1'b0;

      if (canStart)      inFlight <= 1'b1;
      else if (byteDone) inFlight <= 1'b0;

      if (rateUp && state != ST_WAIT) rateHigh <= 1'b1;

      case (state)
        ST_WAIT: begin
          if (released) begin
            state    <= ST_HDR;
            fastLat  <= fastMode;
            keepLat  <= keepBus;
            countLat <= byteCount;
            hdrIdx   <= '0;
          end
        end
        ST_HDR: begin
          if (byteDone) begin
            if (hdrIdx == hdrLast) state <= ST_DATA;
            else                   hdrIdx <= hdrIdx + 1'b1;
          end
        end
        ST_DATA: begin
          if (canStart) startedCnt <= startedCnt + 1'b1;
          if (byteDone) begin
            dataValid <= 1'b1;
            dataOut   <= rxByte;
            if (rxByte != 8'hFF) allOnes <= 1'b0;
          end
          if (dataValid && dataReady) begin
            dataValid <= 1'b0;
            acceptCnt <= acceptCnt + 1'b1;
            if (acceptCnt == countLat - 1'b1) begin
              done    <= 1'b1;
              bootErr <= allOnes;
              state   <= keepLat ? ST_GRANT : ST_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign csN      = !(state == ST_HDR || state == ST_DATA);
  assign busGrant = (state == ST_GRANT);

  AST_SELECT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> $past(released)); // R1
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_WAIT) |=> (state != ST_WAIT)); // R2
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |=> (dataValid && $stable(dataOut))); // R4
  AST_STALL_NO_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataReady) |-> !cmd.startByte); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

endmodule

// File: rtl/boot_stream_reader.sv
`timescale 1ns/1ps
module boot_stream_reader
  import boot_reader_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int DIV_W      = 4,
  parameter int SLOW_HALF  = 8,
  parameter int MIN_HALF   = 1,
  parameter int NUM_PERIPH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  holdAN,
  input  logic                  holdBN,
  input  logic [CNT_W-1:0]      byteCount,
  input  logic                  fastMode,
  input  logic                  rateUp,
  input  logic [DIV_W-1:0]      fastDiv,
  input  logic                  keepBus,
  output logic                  sclk,
  output logic                  csN,
  output logic                  mosi,
  input  logic                  miso,
  output logic [NUM_PERIPH-1:0] periphCsN,
  output logic [7:0]            dataOut,
  output logic                  dataValid,
  input  logic                  dataReady,
  output logic                  done,
  output logic                  bootErr,
  output logic                  busGrant,
  input  logic                  userSclk,
  input  logic                  userMosi,
  input  logic                  userCsN,
  input  logic [NUM_PERIPH-1:0] userPeriphCsN
);

  ctrlCmd_t   cmd;
  logic       dpSclk, dpMosi, byteDone, ctrlCsN;
  logic [7:0] rxByte;

  boot_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .holdAN(holdAN), .holdBN(holdBN),
    .byteCount(byteCount), .fastMode(fastMode), .rateUp(rateUp),
    .keepBus(keepBus), .byteDone(byteDone), .rxByte(rxByte),
    .dataReady(dataReady), .cmd(cmd), .csN(ctrlCsN), .busGrant(busGrant),
    .dataValid(dataValid), .dataOut(dataOut), .done(done), .bootErr(bootErr)
  );

  boot_shift_dp #(.SLOW_HALF(SLOW_HALF), .DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fastDiv(fastDiv), .miso(miso),
    .sclk(dpSclk), .mosi(dpMosi), .byteDone(byteDone), .rxByte(rxByte)
  );

  assign sclk = busGrant ? userSclk : dpSclk;
  assign mosi = busGrant ? userMosi : dpMosi;
  assign csN  = busGrant ? userCsN  : ctrlCsN;

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : gPeriph
    assign periphCsN[g] = busGrant ? userPeriphCsN[g] : 1'b1;
  end

  AST_PERIPH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !busGrant) |-> (&periphCsN)); // R11
  AST_GRANT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |=> busGrant); // R10
  AST_PARK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(done) && !busGrant) |-> (csN && !sclk)); // R9

endmodule

// File: tb/boot_stream_reader_tb_top.sv
`timescale 1ns/1ps
module boot_stream_reader_tb_top;

  localparam int CW = 24, DW = 4, SLOW = 8, MINH = 1, NP = 2;

  logic clk = 0, rstN = 0;
  logic holdAN, holdBN, fastMode, rateUp, keepBus, miso, dataReady;
  logic [CW-1:0] byteCount;
  logic [DW-1:0] fastDiv;
  logic sclk, csN, mosi, dataValid, done, bootErr, busGrant;
  logic [NP-1:0] periphCsN, userPeriphCsN;
  logic [7:0] dataOut;
  logic userSclk, userMosi, userCsN;

  boot_stream_reader #(.CNT_W(CW), .DIV_W(DW), .SLOW_HALF(SLOW), .MIN_HALF(MINH),
                       .NUM_PERIPH(NP)) dut_i (
    .clk(clk), .rstN(rstN), .holdAN(holdAN), .holdBN(holdBN), .byteCount(byteCount),
    .fastMode(fastMode), .rateUp(rateUp), .fastDiv(fastDiv), .keepBus(keepBus),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso), .periphCsN(periphCsN),
    .dataOut(dataOut), .dataValid(dataValid), .dataReady(dataReady), .done(done),
    .bootErr(bootErr), .busGrant(busGrant), .userSclk(userSclk), .userMosi(userMosi),
    .userCsN(userCsN), .userPeriphCsN(userPeriphCsN)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- image and flash model ----------------
  bit blankImg = 0;
  int seed = 0;
  function automatic logic [7:0] img(input int i);
    if (blankImg) return 8'hFF;
    return 8'((i * 29 + seed) ^ (i >> 1));
  endfunction

  int riseCnt = 0, riseCyc = 0, csFalls = 0;
  logic [7:0] mosiSh;
  logic [7:0] hdrCap [0:4];
  int widths [0:511];

  function automatic logic misoFor(input int n);
    int bi, hl;
    logic [7:0] b;
    bi = n / 8;
    hl = (hdrCap[0] == 8'h0B) ? 5 : 4;
    if (bi < hl) return 1'b1;
    b = img(bi - hl);
    return b[7 - (n % 8)];
  endfunction

  always @(posedge sclk) begin
    if (!csN && !busGrant) begin
      logic [7:0] nb;
      nb = {mosiSh[6:0], mosi};
      mosiSh = nb;
      if ((riseCnt % 8) == 7 && (riseCnt / 8) < 5) hdrCap[riseCnt / 8] = nb;
      riseCyc = cyc;
      riseCnt++;
      miso = misoFor(riseCnt);
    end
  end

  always @(negedge sclk) begin
    if (!busGrant && riseCnt > 0 && riseCnt <= 512) widths[riseCnt - 1] = cyc - riseCyc;
  end

  always @(negedge csN) if (!busGrant) csFalls++;

  // ---------------- scoreboard ----------------
  logic [7:0] expQ [$];
  bit readyHold = 0;
  int popCyc = 0, doneCyc = 0, doneCnt = 0;
  bit errAtDone;

  task automatic pushImage(input int n);
    for (int i = 0; i < n; i++) expQ.push_back(img(i));
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        logic nr;
        nr = readyHold ? 1'b0 : (($urandom % 4) != 0);
        dataReady = nr;
        if (dataValid && nr) begin
          logic [7:0] e;
          if (expQ.size() == 0) begin
            check(0, "R4", "unexpected byte", dataOut, -1);
          end else begin
            e = expQ.pop_front();
            check(dataOut == e, "R4", "byte value", dataOut, e);
          end
          popCyc = cyc;
        end
        if (done) begin
          doneCnt++;
          doneCyc = cyc;
          errAtDone = bootErr;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic resetDut();
    rstN = 0;
    holdAN = 0; holdBN = 0; fastMode = 0; rateUp = 0; keepBus = 0;
    byteCount = '0; fastDiv = '0; dataReady = 0;
    userSclk = 0; userMosi = 0; userCsN = 1; userPeriphCsN = '1;
    riseCnt = 0; csFalls = 0; miso = 1'b1; mosiSh = '0;
    for (int i = 0; i < 5; i++) hdrCap[i] = '0;
    for (int i = 0; i < 512; i++) widths[i] = 0;
    expQ.delete(); doneCnt = 0; readyHold = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  task automatic waitDone(input string req);
    int n;
    n = 0;
    while (doneCnt == 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(doneCnt != 0, req, "done timeout", n, 20000);
  endtask

  task automatic checkByteRate(input int b, input int expW, input string req);
    bit same;
    same = 1;
    for (int k = 1; k < 8; k++) if (widths[b*8+k] != widths[b*8]) same = 0;
    check(same, "R6", $sformatf("byte %0d phases uniform", b), widths[b*8+7], widths[b*8]);
    if (expW > 0) check(widths[b*8] == expW, req, $sformatf("byte %0d half period", b),
                        widths[b*8], expW);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- tests ----------------
  initial begin
    int held;
    logic [7:0] heldByte;

    // T1: normal read, slow then rate raise, park afterwards
    seed = 11; blankImg = 0;
    resetDut();
    check(csN && !sclk && !dataValid && !done && !busGrant && (&periphCsN), "R11",
          "reset state", {csN, sclk, dataValid, done, busGrant}, 5'b10000);
    byteCount = 12; fastDiv = 2; keepBus = 0; fastMode = 0;
    pushImage(12);
    holdAN = 0; holdBN = 1;
    repeat (60) @(negedge clk);
    check(csN && riseCnt == 0, "R1", "hold A low keeps bus idle", riseCnt, 0);
    holdAN = 1; holdBN = 0;
    repeat (60) @(negedge clk);
    check(csN && riseCnt == 0, "R1", "hold B low keeps bus idle", riseCnt, 0);
    holdBN = 1;
    repeat (2) @(negedge clk);
    check(csN == 1, "R1", "select still high before sync", csN, 1);
    @(negedge clk);
    check(csN == 0, "R1", "select low after release", csN, 0);
    repeat (300) @(negedge clk);
    check(&periphCsN, "R11", "peripheral selects high during boot", periphCsN, 3);
    repeat (400) @(negedge clk);
    rateUp = 1; @(negedge clk); rateUp = 0;
    // stall across a byte boundary
    readyHold = 1;
    held = 0;
    while (!dataValid && held < 2000) begin @(negedge clk); held++; end
    held = riseCnt; heldByte = dataOut;
    repeat (300) @(negedge clk);
    check(riseCnt == held, "R7", "no serial edges while stalled", riseCnt, held);
    check(dataValid && dataOut == heldByte, "R4", "held byte stable", dataOut, heldByte);
    readyHold = 0;
    waitDone("R8");
    check(hdrCap[0] == 8'h03, "R3", "read command", hdrCap[0], 8'h03);
    check(hdrCap[1] == 0 && hdrCap[2] == 0 && hdrCap[3] == 0, "R3", "zero address",
          {hdrCap[1], hdrCap[2], hdrCap[3]}, 0);
    checkByteRate(0, SLOW, "R5");
    for (int b = 1; b < 15; b++) checkByteRate(b, 0, "R6");
    checkByteRate(15, 2, "R6");
    check(expQ.size() == 0, "R4", "all bytes delivered", expQ.size(), 0);
    check(doneCyc == popCyc + 1, "R8", "done one cycle after last handshake", doneCyc, popCyc + 1);
    check(errAtDone == 0, "R8", "no blank error", errAtDone, 0);
    repeat (100) @(negedge clk);
    check(csN && !sclk && !busGrant, "R9", "bus parked", {csN, sclk, busGrant}, 3'b100);
    check(csFalls == 1, "R2", "single transaction", csFalls, 1);
    check(doneCnt == 1, "R8", "single done pulse", doneCnt, 1);

    // T2: fast read, clamped fast rate, bus grant
    seed = 77; blankImg = 0;
    resetDut();
    byteCount = 8; fastDiv = 0; keepBus = 1; fastMode = 1;
    pushImage(8);
    holdAN = 1; holdBN = 1;
    repeat (100) @(negedge clk);
    rateUp = 1; @(negedge clk); rateUp = 0;
    waitDone("R8");
    check(hdrCap[0] == 8'h0B, "R3", "fast read command", hdrCap[0], 8'h0B);
    check(hdrCap[4] == 8'h00 && hdrCap[3] == 8'h00, "R3", "address tail and dummy",
          {hdrCap[3], hdrCap[4]}, 0);
    checkByteRate(0, SLOW, "R5");
    checkByteRate(5, MINH, "R6");
    checkByteRate(12, MINH, "R6");
    check(expQ.size() == 0, "R4", "fast bytes delivered", expQ.size(), 0);
    check(doneCyc == popCyc + 1, "R8", "done timing fast", doneCyc, popCyc + 1);
    check(busGrant == 1, "R10", "grant after done", busGrant, 1);
    repeat (5) @(negedge clk);
    userSclk = 1; userMosi = 0; userCsN = 0; userPeriphCsN = 2'b01;
    #1;
    check(sclk == 1 && mosi == 0 && csN == 0, "R10", "user pins pass", {sclk, mosi, csN}, 3'b100);
    check(periphCsN == 2'b01, "R11", "user peripheral selects", periphCsN, 1);
    @(negedge clk);
    userSclk = 0; userMosi = 1; userCsN = 1; userPeriphCsN = 2'b10;
    #1;
    check(sclk == 0 && mosi == 1 && csN == 1 && periphCsN == 2'b10, "R10",
          "user pins follow change", {sclk, mosi, csN, periphCsN}, 5'b01110);
    check(csFalls == 1, "R2", "single transaction fast", csFalls, 1);

    // T3: blank image
    seed = 0; blankImg = 1;
    resetDut();
    byteCount = 3; keepBus = 0;
    pushImage(3);
    holdAN = 1; holdBN = 1;
    waitDone("R8");
    check(errAtDone == 1, "R8", "blank image flagged", errAtDone, 1);
    check(expQ.size() == 0, "R4", "blank bytes delivered", expQ.size(), 0);
    repeat (20) @(negedge clk);
    check(doneCnt == 1 && busGrant == 0, "R9", "no grant when parked", busGrant, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule